// File: doc/BRIEF.md
# DRAM Bank Page-Policy Command Scheduler

This block is the command front end for a synchronous DRAM with four banks. It takes one access request at a time over a valid/ready handshake. Each request carries a direction, a bank, a row and a column. The block turns the request into the shortest legal series of row-activate, column read/write and precharge commands on a cycle-based command bus. It keeps, for every bank, whether a row is open and which one. From this it sorts each request into a page hit, an empty bank or a row conflict, and reports that result as a one-cycle pulse that a statistics counter can use. Independent per-bank wait counters let one bank recover from a precharge or activate while another bank is being served.

The static input `close_mode` picks the page policy. With it low (open page), a row stays open after its column access, so a later access to the same row needs only a column command. An access to a different row first closes the bank. With it high (close page), every column command carries the auto-precharge flag. The bank is left closed, and the next access to it begins with an activate. Reads return a fixed burst of four beats. The block signals when those beats are on the data bus: five cycles after the read command, which is an additive latency of two plus a CAS latency of three.

The sequencing state machine has four states. `ST_IDLE` holds ready high and waits for a request. `ST_PRECHARGE` waits for the bank to be free, then closes the open row. `ST_ACTIVATE` waits for the bank, then opens the requested row. `ST_COLUMN` waits for both the bank and the data-bus spacing counter, then issues the read or write. The transitions are as follows. ST_IDLE goes to ST_COLUMN on a hit, to ST_ACTIVATE on an empty bank and to ST_PRECHARGE on a conflict. ST_PRECHARGE goes to ST_ACTIVATE when its precharge is issued. ST_ACTIVATE goes to ST_COLUMN when its activate is issued. ST_COLUMN goes back to ST_IDLE when its column command is issued. In every other case, each state holds.

Top module: `dram_page_sched`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid`, `rd_valid` and `class_valid` are 0, and every bank counts as closed, so the first access to any bank is classified as an empty bank.
- R2: For each accepted request, `class_valid` is 1 for exactly the one cycle after acceptance. `class_kind` then holds 0 for a page hit (the bank is open on the same row), 1 for an empty bank (the bank is closed) or 2 for a row conflict (the bank is open on another row).
- R3: A page hit issues only a column command, with no activate and no precharge.
- R4: A row conflict issues a precharge, then an activate, then the column command, all to the requested bank.
- R5: An empty-bank access issues an activate, then the column command.
- R6: The column command's `cmd_autopre` equals `close_mode`. After a column command with auto-precharge, the bank counts as closed, so a repeat of the same row is classified as an empty bank.
- R7: A column command comes at least T_RCD (3) cycles after the activate to its bank, and exactly T_RCD cycles after it when nothing else delays it.
- R8: An activate comes at least T_RP (3) cycles after a precharge of its bank, and exactly T_RP cycles after it when nothing else delays it. After an auto-precharged column command, the next activate to that bank waits at least 4 + T_RP cycles. A precharge comes at least 4 cycles after a column command to its bank.
- R9: `rd_valid` is 1 for exactly the cycles from 5 to 8 after each READ command, and a WRITE command never raises it.
- R10: Any two column commands are at least 4 cycles apart, whatever their banks.
- R11: `req_ready` is 0 from the cycle after acceptance through the cycle of the column command, and is 1 again in the cycle after it. When the bank is free, the first command comes in the cycle after acceptance.
- R12: `cmd_op` encodes the command as 1 for activate, 2 for read, 3 for write and 4 for precharge, with 0 when `cmd_valid` is 0. `cmd_bank` carries the request bank. `cmd_addr` carries the row, zero-extended, on an activate and the column, zero-extended, on a read or write.
- R13: A request to one bank leaves the open row recorded for every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| close_mode | input | 1 | 1 selects close page with auto-precharge, 0 selects open page |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | 2 | Target bank |
| req_row | input | ROW_W (4) | Target row |
| req_col | input | COL_W (3) | Target column |
| cmd_valid | output | 1 | Command present on the bus this cycle |
| cmd_op | output | 3 | Command code (see R12) |
| cmd_bank | output | 2 | Command bank |
| cmd_addr | output | max(ROW_W,COL_W) (4) | Row on activate, column on read or write |
| cmd_autopre | output | 1 | Auto-precharge flag on a column command |
| rd_valid | output | 1 | A read burst beat is on the data bus |
| class_valid | output | 1 | One-cycle classification pulse |
| class_kind | output | 2 | 0 hit, 1 empty bank, 2 row conflict |

## Verification
A read's four-beat data window often falls in the same cycles as the precharge or activate of the next request. This happens most when the next request targets another bank or conflicts on the same bank. A second overlap comes from a hit that follows quickly: its column command becomes due while the spacing counter from the previous burst is still running. The bench provokes both by sweeping every row pair on every bank in both policies, with an access to a neighbouring bank placed between them, and no idle gap. It judges them with a cycle-stamped monitor. The monitor recomputes from the command log the expected data-valid window and the earliest legal cycle for each command, and compares both with the outputs in every cycle.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } cmd_op_t;

    typedef enum logic [1:0] {
        AC_HIT      = 2'd0,
        AC_EMPTY    = 2'd1,
        AC_CONFLICT = 2'd2
    } access_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRECHARGE,
        ST_ACTIVATE,
        ST_COLUMN
    } sched_state_t;

endpackage

// File: rtl/dps_bank_tracker.sv
module dps_bank_tracker #(
    parameter int ROW_W     = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_pre,
    input  logic             do_act,
    input  logic             do_col,
    input  logic             col_ap,
    input  logic [ROW_W-1:0] act_row,
    output logic             row_open,
    output logic [ROW_W-1:0] open_row,
    output logic             bank_free
);

    localparam int MAX_WAIT = BURST_LEN + T_RP + T_RCD;
    localparam int TMR_W    = $clog2(MAX_WAIT + 1);

    logic [TMR_W-1:0] wait_q;

    // One command per cycle reaches a bank; each loads the wait that must
    // pass before the bank accepts its next command.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q   <= '0;
            row_open <= 1'b0;
            open_row <= '0;
        end else if (do_act) begin
            wait_q   <= TMR_W'(T_RCD - 1);
            row_open <= 1'b1;
            open_row <= act_row;
        end else if (do_pre) begin
            wait_q   <= TMR_W'(T_RP - 1);
            row_open <= 1'b0;
        end else if (do_col) begin
            if (col_ap) begin
                wait_q   <= TMR_W'(BURST_LEN + T_RP - 1);
                row_open <= 1'b0;
            end else begin
                wait_q   <= TMR_W'(BURST_LEN - 1);
            end
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    assign bank_free = (wait_q == '0);

    // R6: auto-precharge leaves the bank closed
    a_r6_ap_closes_row: assert property (@(posedge clk) disable iff (!rst_n)
        (do_col && col_ap) |=> !row_open);

    // R7: an activate blocks the column command for the next cycle
    a_r7_act_blocks_bank: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |=> ((T_RCD < 2) || !bank_free));

    // R8: a precharge closes the row and blocks the next activate
    a_r8_pre_closes_row: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |=> (!row_open && ((T_RP < 2) || !bank_free)));

endmodule

// File: rtl/dps_rd_return.sv
module dps_rd_return #(
    parameter int RD_LAT    = 5,
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    output logic beat_valid
);

    localparam int SR_LEN = RD_LAT - 1;
    localparam int CNT_W  = $clog2(BURST_LEN + 1);

    logic [SR_LEN-1:0] lat_sr;
    logic [CNT_W-1:0]  beats_left;
    logic              launch;

    generate
        if (SR_LEN == 1) begin : g_short
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lat_sr <= '0;
                else        lat_sr <= rd_issue;
            end
        end else begin : g_long
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lat_sr <= '0;
                else        lat_sr <= {lat_sr[SR_LEN-2:0], rd_issue};
            end
        end
    endgenerate

    assign launch = lat_sr[SR_LEN-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 beats_left <= '0;
        else if (launch)            beats_left <= CNT_W'(BURST_LEN);
        else if (beats_left != '0)  beats_left <= beats_left - 1'b1;
    end

    assign beat_valid = (beats_left != '0);

    // R9: a new burst only starts in the last beat of the previous one or later
    a_r9_no_burst_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (beats_left <= CNT_W'(1)));

endmodule

// File: rtl/dram_page_sched.sv
module dram_page_sched #(
    parameter int NBANK     = 4,
    parameter int ROW_W     = 4,
    parameter int COL_W     = 3,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int ADD_LAT   = 2,
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = $clog2(NBANK),
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_autopre,
    output logic              rd_valid,
    output logic              class_valid,
    output logic [1:0]        class_kind
);
    import dps_pkg::*;

    localparam int RD_LAT = ADD_LAT + CAS_LAT;
    localparam int GAP_W  = $clog2(BURST_LEN + 1);

    sched_state_t      state, state_nx;
    access_kind_t      req_kind, kind_q;
    cmd_op_t           op_e;

    logic              q_write;
    logic [BANK_W-1:0] q_bank;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;

    logic [NBANK-1:0]  trk_open;
    logic [NBANK-1:0]  trk_free;
    logic [ROW_W-1:0]  trk_row [NBANK];

    logic [GAP_W-1:0]  col_gap;
    logic              accept;
    logic              issue_pre, issue_act, issue_col;
    logic              sel_free;
    logic              class_q;

    assign accept   = req_valid && req_ready;
    assign sel_free = trk_free[q_bank];

    // ---------------- per-bank state ----------------
    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            logic hit_bank;
            assign hit_bank = (q_bank == BANK_W'(g));
            dps_bank_tracker #(
                .ROW_W     (ROW_W),
                .T_RCD     (T_RCD),
                .T_RP      (T_RP),
                .BURST_LEN (BURST_LEN)
            ) u_trk (
                .clk       (clk),
                .rst_n     (rst_n),
                .do_pre    (issue_pre && hit_bank),
                .do_act    (issue_act && hit_bank),
                .do_col    (issue_col && hit_bank),
                .col_ap    (close_mode),
                .act_row   (q_row),
                .row_open  (trk_open[g]),
                .open_row  (trk_row[g]),
                .bank_free (trk_free[g])
            );
        end
    endgenerate

    // ---------------- classification ----------------
    always_comb begin
        if (!trk_open[req_bank])
            req_kind = AC_EMPTY;
        else if (trk_row[req_bank] == req_row)
            req_kind = AC_HIT;
        else
            req_kind = AC_CONFLICT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            class_q <= 1'b0;
            kind_q  <= AC_HIT;
        end else begin
            class_q <= accept;
            if (accept) kind_q <= req_kind;
        end
    end

    assign class_valid = class_q;
    assign class_kind  = kind_q;

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write <= 1'b0;
            q_bank  <= '0;
            q_row   <= '0;
            q_col   <= '0;
        end else if (accept) begin
            q_write <= req_write;
            q_bank  <= req_bank;
            q_row   <= req_row;
            q_col   <= req_col;
        end
    end

    // ---------------- data-bus spacing ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              col_gap <= '0;
        else if (issue_col)      col_gap <= GAP_W'(BURST_LEN - 1);
        else if (col_gap != '0)  col_gap <= col_gap - 1'b1;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- command outputs ----------------
    always_comb begin
        req_ready   = 1'b0;
        cmd_valid   = 1'b0;
        op_e        = OP_NOP;
        cmd_addr    = '0;
        cmd_autopre = 1'b0;
        issue_pre   = 1'b0;
        issue_act   = 1'b0;
        issue_col   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_PRECHARGE: begin
                if (sel_free) begin
                    cmd_valid = 1'b1;
                    op_e      = OP_PRE;
                    issue_pre = 1'b1;
                end
            end
            ST_ACTIVATE: begin
                if (sel_free) begin
                    cmd_valid = 1'b1;
                    op_e      = OP_ACT;
                    cmd_addr  = ADDR_W'(q_row);
                    issue_act = 1'b1;
                end
            end
            ST_COLUMN: begin
                if (sel_free && (col_gap == '0)) begin
                    cmd_valid   = 1'b1;
                    op_e        = q_write ? OP_WR : OP_RD;
                    cmd_addr    = ADDR_W'(q_col);
                    cmd_autopre = close_mode;
                    issue_col   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign cmd_op   = op_e;
    assign cmd_bank = q_bank;

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (req_kind)
                        AC_HIT:      state_nx = ST_COLUMN;
                        AC_EMPTY:    state_nx = ST_ACTIVATE;
                        AC_CONFLICT: state_nx = ST_PRECHARGE;
                        default:     state_nx = ST_ACTIVATE;
                    endcase
                end
            end
            ST_PRECHARGE: if (issue_pre) state_nx = ST_ACTIVATE;
            ST_ACTIVATE:  if (issue_act) state_nx = ST_COLUMN;
            ST_COLUMN:    if (issue_col) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // ---------------- read data return ----------------
    dps_rd_return #(
        .RD_LAT    (RD_LAT),
        .BURST_LEN (BURST_LEN)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_issue   (issue_col && !q_write),
        .beat_valid (rd_valid)
    );

    // R10: column commands never back to back
    a_r10_col_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        issue_col |=> !issue_col);

    // R11: ready returns right after the column command
    a_r11_ready_after_col: assert property (@(posedge clk) disable iff (!rst_n)
        issue_col |=> req_ready);

    // R11: busy once a request is taken
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R2: classification is a single-cycle pulse
    a_r2_class_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |=> !class_valid);

    // R2: classification only follows an accepted request
    a_r2_class_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        class_valid |-> $past(accept));

endmodule

// File: tb/tb_dram_page_sched.sv
module tb_dram_page_sched;

    localparam int T_RCD  = 3;
    localparam int T_RP   = 3;
    localparam int BURST  = 4;
    localparam int RD_LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       close_mode = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [3:0] req_row = '0;
    logic [2:0] req_col = '0;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [1:0] cmd_bank;
    logic [3:0] cmd_addr;
    logic       cmd_autopre;
    logic       rd_valid;
    logic       class_valid;
    logic [1:0] class_kind;

    always #10 clk = ~clk;

    dram_page_sched dut (
        .clk(clk), .rst_n(rst_n), .close_mode(close_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .cmd_autopre(cmd_autopre), .rd_valid(rd_valid),
        .class_valid(class_valid), .class_kind(class_kind)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench model of open rows
    bit m_open [4];
    int m_row  [4];

    // command log for the current request
    int n_log = 0;
    int log_op [8];
    int log_cyc[8];
    int log_bank[8];
    int log_addr[8];
    int log_ap [8];

    // earliest legal cycles
    int e_act[4];
    int e_col[4];
    int e_pre[4];
    int e_col_any = 0;
    int rd_last = -100;
    int rd_prev = -100;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // cycle monitor
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_rd;
            exp_rd = ((cyc - rd_last >= RD_LAT) && (cyc - rd_last < RD_LAT + BURST)) ||
                     ((cyc - rd_prev >= RD_LAT) && (cyc - rd_prev < RD_LAT + BURST));
            chk(rd_valid == exp_rd, "R9 read beat window", rd_valid, exp_rd);
            if (!cmd_valid) chk(cmd_op == 0, "R12 idle op code", cmd_op, 0);
            if (cmd_valid) begin
                int b;
                b = cmd_bank;
                chk(cmd_op >= 1 && cmd_op <= 4, "R12 op code range", cmd_op, 1);
                if (cmd_op == 1) begin
                    chk(cyc >= e_act[b], "R8 activate after precharge", cyc, e_act[b]);
                    e_col[b] = cyc + T_RCD;
                end else if (cmd_op == 2 || cmd_op == 3) begin
                    chk(cyc >= e_col[b], "R7 column after activate", cyc, e_col[b]);
                    chk(cyc >= e_col_any, "R10 column spacing", cyc, e_col_any);
                    e_col_any = cyc + BURST;
                    e_pre[b] = cyc + BURST;
                    if (cmd_autopre) e_act[b] = cyc + BURST + T_RP;
                    if (cmd_op == 2) begin
                        rd_prev = rd_last;
                        rd_last = cyc;
                    end
                end else if (cmd_op == 4) begin
                    chk(cyc >= e_pre[b], "R8 precharge after burst", cyc, e_pre[b]);
                    e_act[b] = cyc + T_RP;
                end
                if (n_log < 8) begin
                    log_op[n_log]   = cmd_op;
                    log_cyc[n_log]  = cyc;
                    log_bank[n_log] = cmd_bank;
                    log_addr[n_log] = cmd_addr;
                    log_ap[n_log]   = cmd_autopre;
                    n_log++;
                end
            end
        end
    end

    task automatic do_req(bit w, int b, int r, int c, bit quiet, output int got);
        int ek, acc, ci, exp_len, idx;
        bit found;
        string tg;
        if (quiet) repeat (12) @(negedge clk);
        ek = !m_open[b] ? 1 : ((m_row[b] == r) ? 0 : 2);
        tg = (ek == 0) ? "R3 hit sequence" : (ek == 1) ? "R5 empty sequence" : "R4 conflict sequence";
        @(negedge clk); #1;
        req_write = w; req_bank = 2'(b); req_row = 4'(r); req_col = 3'(c); req_valid = 1'b1;
        while (!req_ready) begin @(negedge clk); #1; end
        acc = cyc;
        n_log = 0;
        @(negedge clk); #1;
        req_valid = 1'b0;
        got = class_kind;
        chk(class_valid == 1'b1, "R2 class pulse", class_valid, 1);
        chk(class_kind == ek, "R2 class kind", class_kind, ek);
        chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
        found = 0; ci = -1;
        while (!found) begin
            for (int i = 0; i < n_log; i++)
                if (!found && (log_op[i] == 2 || log_op[i] == 3)) begin found = 1; ci = i; end
            if (!found) begin @(negedge clk); #1; end
        end
        @(negedge clk); #1;
        chk(req_ready == 1'b1, "R11 ready after column", req_ready, 1);
        exp_len = (ek == 0) ? 1 : (ek == 1) ? 2 : 3;
        chk(n_log == exp_len, tg, n_log, exp_len);
        if (n_log == exp_len) begin
            idx = 0;
            for (int i = 0; i < n_log; i++) chk(log_bank[i] == b, "R12 bank field", log_bank[i], b);
            if (ek == 2) begin
                chk(log_op[0] == 4, "R4 precharge first", log_op[0], 4);
                idx++;
            end
            if (ek >= 1) begin
                chk(log_op[idx] == 1, tg, log_op[idx], 1);
                chk(log_addr[idx] == r, "R12 activate row", log_addr[idx], r);
                idx++;
            end
            chk(log_op[idx] == (w ? 3 : 2), "R12 column op", log_op[idx], w ? 3 : 2);
            chk(log_addr[idx] == c, "R12 column addr", log_addr[idx], c);
            chk(log_ap[idx] == close_mode, "R6 auto-precharge flag", log_ap[idx], close_mode);
            if (quiet) begin
                chk(log_cyc[0] == acc + 1, "R11 first command timing", log_cyc[0], acc + 1);
                if (ek == 2) chk(log_cyc[1] - log_cyc[0] == T_RP, "R8 exact precharge gap",
                                 log_cyc[1] - log_cyc[0], T_RP);
                if (ek >= 1) chk(log_cyc[idx] - log_cyc[idx-1] == T_RCD, "R7 exact activate gap",
                                 log_cyc[idx] - log_cyc[idx-1], T_RCD);
            end
        end
        if (close_mode) m_open[b] = 1'b0;
        else begin m_open[b] = 1'b1; m_row[b] = r; end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int k;
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0; m_row[i] = 0; e_act[i] = 0; e_col[i] = 0; e_pre[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1 no command after reset", cmd_valid, 0);
        chk(rd_valid == 1'b0, "R1 no data after reset", rd_valid, 0);
        chk(class_valid == 1'b0, "R1 no class after reset", class_valid, 0);

        // open page directed (R1: first access is empty)
        close_mode = 1'b0;
        do_req(0, 0, 2, 5, 1, k);
        chk(k == 1, "R1 first access empty", k, 1);
        do_req(0, 0, 2, 6, 1, k);
        chk(k == 0, "R3 same row hit", k, 0);
        do_req(1, 0, 5, 1, 1, k);
        chk(k == 2, "R4 other row conflict", k, 2);
        do_req(0, 1, 7, 3, 1, k);
        do_req(0, 0, 5, 2, 1, k);
        chk(k == 0, "R13 other bank untouched", k, 0);

        // close page directed
        close_mode = 1'b1;
        do_req(0, 2, 3, 4, 1, k);
        do_req(0, 2, 3, 4, 1, k);
        chk(k == 1, "R6 repeat row is empty", k, 1);
        do_req(1, 0, 5, 7, 1, k);
        chk(k == 0, "R6 open row hit in close mode", k, 0);
        do_req(0, 0, 5, 7, 0, k);
        chk(k == 1, "R6 bank closed after auto-precharge", k, 1);

        // back-to-back sweep over policies, banks and row pairs
        for (int m = 0; m < 2; m++) begin
            close_mode = m[0];
            for (int b = 0; b < 4; b++)
                for (int r0 = 0; r0 < 4; r0++)
                    for (int r1 = 0; r1 < 4; r1++) begin
                        do_req(((r0 + r1) & 1) == 1, b, r0, r0 + r1, 0, k);
                        do_req((r1 & 1) == 0, (b + 1) % 4, r1 + 4, r0, 0, k);
                        do_req(0, b, r1, r1, 0, k);
                    end
        end
        repeat (12) @(negedge clk);
        summary();
        $finish;
    end

endmodule